// File: doc/BRIEF.md
# Rate-Compensated Beep Tone Generator

This block makes a square-wave beep tone from a free-running counter that advances once every two system clocks. Software picks which counter bit drives the tone by writing a one-hot select field. It switches the tone on or off with a single enable bit. The counter always runs, so the tone phase follows from the time since reset.

The frequency sequencer reports whether the system clock is at full rate, half rate or 1/32 rate. When the clock is slowed, the block moves the tapped bit down by a fixed number of positions. The tone period measured in real time therefore stays the same across power-saving modes. A slowed clock cannot run a faster tone than the counter provides, so a shift that would go below bit 0 stops at bit 0.

Top module: `beep_tone_gen`

## Requirements
- R1: After `rst_ni` is released, the enable bit and the select field are clear, `beep_o` is low, and the counter starts from zero.
- R2: The counter increments on every second rising clock edge after reset, starting with the second one. With select bit k in full mode, `beep_o` follows counter bit k, so bit 10 gives a tone period of 2^12 clocks.
- R3: A write with `wr_addr_i`=1 loads the select field from `wr_data_i[18:10]`. Data bit k there selects counter bit k.
- R4: When more than one select bit is set, the lowest set bit is used.
- R5: When the select field is zero, `beep_o` stays low.
- R6: A write with `wr_addr_i`=0 loads the enable bit from `wr_data_i[0]`. While enable is 0, `beep_o` is low and the counter keeps running.
- R7: Writing to any data bit outside bit 0 (enable) or bits 18:10 (select) has no effect.
- R8: `freq_mode_i`=2'b01 (half rate) moves the tap one bit lower.
- R9: `freq_mode_i`=2'b10 (1/32 rate) moves the tap `SLOW_SHIFT` (default 5) bits lower, saturating at bit 0.
- R10: `freq_mode_i`=2'b00 (full rate) and the unused code 2'b11 both use the selected bit unchanged.
- R11: A register write takes effect from the clock edge that samples `wr_en_i`. A change of `freq_mode_i` affects `beep_o` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 1 | 0 = control (enable), 1 = tap select |
| wr_data_i | input | DW | Write data |
| freq_mode_i | input | 2 | Current system clock rate code |
| beep_o | output | 1 | Beep square wave |

## Verification
The bench builds the block twice, sharing one stimulus stream. The first copy uses the default parameters, with the select field at bits 18:10 and a slow shift of 5. The second copy raises `SLOW_SHIFT` to 12, so a low select bit in 1/32 mode drives the tap below zero. That brings the saturation at bit 0 within reach, which the default shifts never reach. Every output is compared each cycle against a counter model kept in the bench, so the phase after a long disabled stretch is checked as well as the pitch.

// File: rtl/beep_pkg.sv
package beep_pkg;
  typedef enum logic [1:0] {
    FM_FULL = 2'b00,
    FM_HALF = 2'b01,
    FM_SLOW = 2'b10,
    FM_RSVD = 2'b11
  } freq_mode_e;

  localparam logic REG_CTRL = 1'b0;
  localparam logic REG_TAP  = 1'b1;
endpackage

// File: rtl/beep_prescale_cnt.sv
module beep_prescale_cnt #(
  parameter int CNT_W = 19
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [CNT_W-1:0] cnt_o
);
  logic             ph_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q  <= 1'b0;
      cnt_q <= '0;
    end else begin
      ph_q <= ~ph_q;
      if (ph_q) cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign cnt_o = cnt_q;

  // R2
  cnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ph_q |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));
  // R2
  cnt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ph_q |=> $stable(cnt_q));
endmodule

// File: rtl/beep_regs.sv
module beep_regs #(
  parameter int DW     = 32,
  parameter int SEL_LO = 10,
  parameter int SEL_HI = 18,
  localparam int SEL_W = SEL_HI - SEL_LO + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic             wr_addr_i,
  input  logic [DW-1:0]    wr_data_i,
  output logic             en_o,
  output logic [SEL_W-1:0] sel_o
);
  import beep_pkg::*;

  logic             en_q;
  logic [SEL_W-1:0] sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      sel_q <= '0;
    end else if (wr_en_i) begin
      if (wr_addr_i == REG_CTRL) en_q  <= wr_data_i[0];
      else                       sel_q <= wr_data_i[SEL_HI:SEL_LO];
    end
  end

  assign en_o  = en_q;
  assign sel_o = sel_q;

  // R11
  sel_upd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == REG_TAP) |=> (sel_o == $past(wr_data_i[SEL_HI:SEL_LO])));
  // R7
  en_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && wr_addr_i == REG_CTRL) |=> $stable(en_o));
endmodule

// File: rtl/beep_tap_sel.sv
module beep_tap_sel #(
  parameter int SEL_LO     = 10,
  parameter int SEL_HI     = 18,
  parameter int HALF_SHIFT = 1,
  parameter int SLOW_SHIFT = 5,
  localparam int SEL_W = SEL_HI - SEL_LO + 1,
  localparam int IDX_W = $clog2(SEL_HI + 1)
) (
  input  logic [SEL_W-1:0]           sel_i,
  input  beep_pkg::freq_mode_e       mode_i,
  output logic [IDX_W-1:0]           tap_o,
  output logic                       valid_o
);
  import beep_pkg::*;

  logic [IDX_W-1:0] base;
  logic [IDX_W-1:0] sh;

  always_comb begin
    base    = '0;
    valid_o = 1'b0;
    // descending scan: lowest set bit wins
    for (int i = SEL_W - 1; i >= 0; i--) begin
      if (sel_i[i]) begin
        base    = IDX_W'(SEL_LO + i);
        valid_o = 1'b1;
      end
    end
    case (mode_i)
      FM_HALF: sh = IDX_W'(HALF_SHIFT);
      FM_SLOW: sh = IDX_W'(SLOW_SHIFT);
      default: sh = '0;
    endcase
    tap_o = (base >= sh) ? base - sh : '0;
  end
endmodule

// File: rtl/beep_tone_gen.sv
module beep_tone_gen #(
  parameter int DW         = 32,
  parameter int SEL_LO     = 10,
  parameter int SEL_HI     = 18,
  parameter int HALF_SHIFT = 1,
  parameter int SLOW_SHIFT = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic          wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic [1:0]    freq_mode_i,
  output logic          beep_o
);
  import beep_pkg::*;

  localparam int CNT_W = SEL_HI + 1;
  localparam int SEL_W = SEL_HI - SEL_LO + 1;
  localparam int IDX_W = $clog2(SEL_HI + 1);

  logic [CNT_W-1:0] cnt;
  logic             en;
  logic [SEL_W-1:0] sel;
  logic [IDX_W-1:0] tap;
  logic             tap_valid;
  freq_mode_e       mode;

  assign mode = freq_mode_e'(freq_mode_i);

  beep_prescale_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .cnt_o (cnt)
  );

  beep_regs #(.DW(DW), .SEL_LO(SEL_LO), .SEL_HI(SEL_HI)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i),
    .en_o     (en),
    .sel_o    (sel)
  );

  beep_tap_sel #(
    .SEL_LO(SEL_LO), .SEL_HI(SEL_HI),
    .HALF_SHIFT(HALF_SHIFT), .SLOW_SHIFT(SLOW_SHIFT)
  ) u_tap (
    .sel_i  (sel),
    .mode_i (mode),
    .tap_o  (tap),
    .valid_o(tap_valid)
  );

  assign beep_o = en & tap_valid & cnt[tap];

  // R6
  off_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en |-> !beep_o);
  // R5
  nosel_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel == '0) |-> !beep_o);
  // R10
  tap_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tap_valid && (mode == FM_FULL || mode == FM_RSVD)) |-> (tap >= IDX_W'(SEL_LO)));
  // R9
  tap_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tap_valid |-> (tap <= IDX_W'(SEL_HI)));
endmodule

// File: tb/tb_beep_tone_gen.sv
`timescale 1ns/1ps
module tb_beep_tone_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        wr_addr = 1'b0;
  logic [31:0] wr_data = '0;
  logic [1:0]  mode = 2'b00;
  logic        beep, beep_sat;

  int checks = 0;
  int failures = 0;
  int unsigned n_edges = 0;
  bit          en_sh = 1'b0;
  logic [31:0] tap_sh = '0;

  always #5 clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) n_edges <= 0;
    else        n_edges <= n_edges + 1;
  end

  beep_tone_gen dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .freq_mode_i(mode), .beep_o(beep));

  beep_tone_gen #(.SLOW_SHIFT(12)) dut_sat (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .freq_mode_i(mode), .beep_o(beep_sat));

  function automatic bit exp_beep(int unsigned n, bit en, logic [31:0] w,
                                  logic [1:0] m, int slow_sh);
    int tap = -1;
    int sh;
    for (int i = 18; i >= 10; i--) if (w[i]) tap = i;
    if (!en || tap < 0) return 1'b0;
    sh = (m == 2'b01) ? 1 : (m == 2'b10) ? slow_sh : 0;
    tap = (tap >= sh) ? tap - sh : 0;
    return bit'(((n >> 1) >> tap) & 1);
  endfunction

  task automatic wr(input logic a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
    if (a == 1'b0) en_sh = d[0];
    else           tap_sh = d;
  endtask

  task automatic span(input int ncyc, input string req);
    bit bad = 1'b0;
    bit e1, e2;
    repeat (ncyc) begin
      @(negedge clk);
      e1 = exp_beep(n_edges, en_sh, tap_sh, mode, 5);
      e2 = exp_beep(n_edges, en_sh, tap_sh, mode, 12);
      if (!bad && (beep !== e1 || beep_sat !== e2)) begin
        $display("FAIL %s at edge %0d: actual beep=%b sat=%b expected beep=%b sat=%b",
                 req, n_edges, beep, beep_sat, e1, e2);
        bad = 1'b1;
      end
    end
    checks++;
    if (bad) failures++;
  endtask

  initial begin
    #1_900_000;
    $display("FAIL watchdog expired: actual hung expected finish");
    failures++;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures + 0);
    $finish;
  end

  initial begin
    void'($urandom(32'h0000_BEEF));
    repeat (3) @(negedge clk);
    checks++;
    if (beep !== 1'b0 || beep_sat !== 1'b0) begin
      failures++;
      $display("FAIL R1 in reset: actual %b/%b expected 0/0", beep, beep_sat);
    end
    rst_n = 1'b1;
    span(50, "R1");
    // R1: counter starts at zero (phase matches model from reset)
    wr(1'b1, 32'h1 << 10);
    wr(1'b0, 32'h1);
    span(9000, "R2 R3");
    wr(1'b1, (32'h1 << 11) | (32'h1 << 14));
    span(9000, "R4");
    wr(1'b1, 32'h0);
    span(3000, "R5");
    wr(1'b1, 32'h1 << 10);
    wr(1'b0, 32'h0);
    span(3000, "R6 off");
    wr(1'b0, 32'h1);
    span(3000, "R6 phase");
    wr(1'b0, 32'hFFFF_FFFE);
    span(2000, "R7 ctrl");
    wr(1'b0, 32'h1);
    wr(1'b1, 32'hFFF8_03FF | (32'h1 << 11));
    span(5000, "R7 tap");
    wr(1'b1, 32'h1 << 10);
    mode = 2'b01;
    span(3000, "R8");
    wr(1'b1, 32'h1 << 18);
    mode = 2'b10;
    span(33000, "R9");
    wr(1'b1, 32'h1 << 10);
    span(1000, "R9 sat");
    mode = 2'b11;
    span(5000, "R10");
    mode = 2'b00;
    wr(1'b1, 32'h1 << 11);
    span(100, "R11");
    mode = 2'b01;
    span(100, "R11 mode");
    for (int k = 0; k < 20; k++) begin
      logic [31:0] w = $urandom;
      if ($urandom % 4 == 0) w[18:10] = '0;
      wr(1'b1, w);
      wr(1'b0, 32'($urandom % 5 != 0));
      mode = 2'($urandom % 4);
      span(300 + int'($urandom % 1700), "R2 rand");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule